// File: doc/BRIEF.md
# Pixel Clock Divider with Bypass

This block turns a fast reference clock into pixel-rate timing. It does not make a new clock net. It drives single-cycle enable pulses in the reference domain: one marks each rising edge of the divided pixel clock, and one marks each falling edge. A third pulse, the launch enable, tells the pixel pipeline when to drive new data. The launch enable follows either the rising or the falling pulse, chosen by an inversion bit.

The block is set up through one 32-bit timing register. That register also carries unrelated fields, such as sync polarities and line length. The divide ratio comes from a 10-bit field split into two 5-bit fragments:

| Part | Bits |
|---|---|
| Low fragment | [4:0] |
| High fragment | [31:27] |
| Bypass bit | 26 |
| Inversion bit | 11 |

The block has two write ports:
- A full write replaces the whole register.
- A divisor-only write replaces just the bypass bit and the two fragments, and leaves every other bit of the register alone.

A new setting takes effect only when the current pixel period ends, so the output never contains a shortened period.

Top module: `pixclk_div`

## Requirements
- R1: After reset the register reads 0, the active ratio is 2 and rise and launch pulses occur in the first cycle after reset is released.
- R2: With the bypass bit (bit 26) set, the rise and fall enables are both high on every reference cycle and the divisor field has no effect.
- R3: With bypass clear, the rise enable repeats every F+2 reference cycles, where F = {wrData[31:27], wrData[4:0]} as last written (high fragment supplies the upper 5 bits), giving ratios 2 to 1025.
- R4: The rise enable is high for exactly one cycle per period, at count 0. The fall enable is high at count ceil(R/2), where R is the ratio, so even ratios give equal halves and odd ratios give a high phase one cycle longer.
- R5: With the inversion bit (bit 11) clear, the launch enable equals the rise enable. With it set, the launch enable equals the fall enable.
- R6: A written setting (ratio, bypass, inversion) becomes active only at the end of the period in progress; the period during which the write lands keeps its old length.
- R7: A full write (regWrEn) stores all 32 bits, and rdData returns them from the next cycle.
- R8: A divisor-only write (divWrEn) updates bits 31:26 and 4:0 from wrData and leaves every other register bit unchanged.
- R9: When both write strobes are high in the same cycle, the full write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Full register write strobe |
| divWrEn | input | 1 | Divisor-only write strobe (bypass and fragments) |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Current register contents |
| riseEn | output | 1 | One-cycle pulse at each divided-clock rising edge |
| fallEn | output | 1 | One-cycle pulse at each divided-clock falling edge |
| launchEn | output | 1 | Pulse on which pixel data is launched |

## Verification
A cycle-accurate reference model in the bench runs alongside the design. It is fed with seeded random full writes, divisor-only writes and colliding writes. The random writes mix small ratios, bypass and inversion, so period length, duty point and launch-edge selection are all compared on every cycle.

Directed cases cover the corners:
- Fragment values that only decode correctly when the high part lands in the upper bits.
- The largest ratio, 1025.
- A bypass write carrying a non-zero field, to show the field is ignored.
- A ratio change placed right after a rise pulse, to separate adoption at the wrap from immediate adoption.

Readback is compared every cycle, which exposes any divisor-only write that disturbs the neighbouring fields.

// File: rtl/pixdiv_pkg.sv
package pixdiv_pkg;
  localparam int REG_W   = 32;
  localparam int LO_W    = 5;
  localparam int HI_W    = 5;
  localparam int LO_POS  = 0;
  localparam int HI_POS  = 27;
  localparam int BYP_POS = 26;
  localparam int INV_POS = 11;
  localparam int FIELD_W = LO_W + HI_W;

  // Decoded configuration plus a strobe saying the register changed
  // since the datapath last adopted it.
  typedef struct packed {
    logic               dirty;
    logic               bypass;
    logic               invert;
    logic [FIELD_W-1:0] field;
  } cfg_stb_t;
endpackage

// File: rtl/pixdiv_ctrl.sv
module pixdiv_ctrl
  import pixdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             regWrEn,
  input  logic             divWrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             wrapNow,
  output logic [REG_W-1:0] rdData,
  output cfg_stb_t         cfgOut
);
  localparam logic [REG_W-1:0] LO_MASK  = REG_W'((1 << LO_W) - 1) << LO_POS;
  localparam logic [REG_W-1:0] HI_MASK  = REG_W'((1 << HI_W) - 1) << HI_POS;
  localparam logic [REG_W-1:0] BYP_MASK = REG_W'(1) << BYP_POS;
  localparam logic [REG_W-1:0] DIV_MASK = LO_MASK | HI_MASK | BYP_MASK;

  logic [REG_W-1:0] timReg;
  logic             cfgDirty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timReg <= '0;
    end else if (regWrEn) begin
      timReg <= wrData;
    end else if (divWrEn) begin
      timReg <= (timReg & ~DIV_MASK) | (wrData & DIV_MASK);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfgDirty <= 1'b0;
    end else if (regWrEn || divWrEn) begin
      cfgDirty <= 1'b1;
    end else if (wrapNow) begin
      cfgDirty <= 1'b0;
    end
  end

  always_comb begin
    rdData        = timReg;
    cfgOut.dirty  = cfgDirty;
    cfgOut.bypass = timReg[BYP_POS];
    cfgOut.invert = timReg[INV_POS];
    cfgOut.field  = {timReg[HI_POS +: HI_W], timReg[LO_POS +: LO_W]};
  end

  AST_FULL_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    regWrEn |=> rdData == $past(wrData)); // R7
  AST_DIV_KEEPS_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
    (divWrEn && !regWrEn) |=> (rdData & ~DIV_MASK) == $past(rdData & ~DIV_MASK)); // R8
  AST_FULL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (divWrEn && regWrEn) |=> rdData == $past(wrData)); // R9
endmodule

// File: rtl/pixdiv_dp.sv
module pixdiv_dp
  import pixdiv_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  cfg_stb_t cfgIn,
  output logic     wrapNow,
  output logic     riseEn,
  output logic     fallEn,
  output logic     launchEn
);
  localparam int CNT_W = FIELD_W + 1;

  logic               actBypass;
  logic               actInvert;
  logic [FIELD_W-1:0] actField;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   lastIdx;
  logic [CNT_W-1:0]   halfIdx;

  always_comb begin
    lastIdx = actBypass ? '0 : CNT_W'(actField) + CNT_W'(1);
    halfIdx = (CNT_W'(actField) + CNT_W'(3)) >> 1;
    wrapNow = (cnt == lastIdx);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (wrapNow) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      actBypass <= 1'b0;
      actInvert <= 1'b0;
      actField  <= '0;
    end else if (wrapNow && cfgIn.dirty) begin
      actBypass <= cfgIn.bypass;
      actInvert <= cfgIn.invert;
      actField  <= cfgIn.field;
    end
  end

  always_comb begin
    riseEn   = (cnt == '0);
    fallEn   = actBypass || (cnt == halfIdx);
    launchEn = actInvert ? fallEn : riseEn;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= lastIdx); // R4
  AST_HOLD_MID_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    !wrapNow |=> $stable({actBypass, actInvert, actField})); // R6
  AST_BYPASS_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
    actBypass |-> (riseEn && fallEn)); // R2
  AST_RISE_AFTER_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    wrapNow |=> riseEn); // R3
endmodule

// File: rtl/pixclk_div.sv
module pixclk_div
  import pixdiv_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        regWrEn,
  input  logic        divWrEn,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        riseEn,
  output logic        fallEn,
  output logic        launchEn
);
  cfg_stb_t cfgStb;
  logic     wrapNow;

  pixdiv_ctrl i_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .regWrEn (regWrEn),
    .divWrEn (divWrEn),
    .wrData  (wrData),
    .wrapNow (wrapNow),
    .rdData  (rdData),
    .cfgOut  (cfgStb)
  );

  pixdiv_dp i_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfgIn    (cfgStb),
    .wrapNow  (wrapNow),
    .riseEn   (riseEn),
    .fallEn   (fallEn),
    .launchEn (launchEn)
  );
endmodule

// File: tb/test_pixclk_div.sv
module test_pixclk_div;
  localparam logic [31:0] DIVM = 32'hFC00_001F;
  localparam int          INVB = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regWrEn = 1'b0;
  logic        divWrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        riseEn, fallEn, launchEn;

  int nChecks = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  pixclk_div i_pixclk_div (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .divWrEn(divWrEn),
    .wrData(wrData), .rdData(rdData), .riseEn(riseEn), .fallEn(fallEn),
    .launchEn(launchEn)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int fieldOf(input logic [31:0] r);
    return int'({r[31:27], r[4:0]});
  endfunction

  function automatic int ratioOf(input logic [31:0] r);
    return r[26] ? 1 : fieldOf(r) + 2;
  endfunction

  function automatic logic [31:0] mkReg(input bit byp, input bit inv,
                                        input int hi, input int lo,
                                        input logic [31:0] other);
    logic [31:0] r;
    r = other & ~DIVM & ~(32'h1 << INVB);
    r[31:27] = hi[4:0];
    r[4:0]   = lo[4:0];
    r[26]    = byp;
    r[INVB]  = inv;
    return r;
  endfunction

  // Reference model, evaluated between edges
  logic [31:0] mReg;
  int          mCnt, mField;
  bit          mBy, mInv, mDirty;
  string       rdTag = "R7";

  always @(negedge clk) begin
    if (!rst_n) begin
      mReg = '0; mCnt = 0; mField = 0; mBy = 0; mInv = 0; mDirty = 0;
    end else begin
      int lastI, halfI;
      bit eRise, eFall;
      lastI = mBy ? 0 : mField + 1;
      halfI = (mField + 3) / 2;
      eRise = (mCnt == 0);
      eFall = mBy || (mCnt == halfI);
      chk(riseEn == eRise, mBy ? "R2" : "R4", "rise", riseEn, eRise);
      chk(fallEn == eFall, mBy ? "R2" : "R4", "fall", fallEn, eFall);
      chk(launchEn == (mInv ? eFall : eRise), "R5", "launch", launchEn,
          mInv ? eFall : eRise);
      chk(rdData == mReg, rdTag, "readback", rdData, mReg);
      // R6: adopt the stored setting only when the period wraps
      if (mCnt == lastI) begin
        mCnt = 0;
        if (mDirty) begin
          mBy = mReg[26]; mInv = mReg[INVB]; mField = fieldOf(mReg); mDirty = 0;
        end
      end else begin
        mCnt++;
      end
      if (regWrEn) begin
        mReg = wrData; mDirty = 1;
        rdTag = divWrEn ? "R9" : "R7";
      end else if (divWrEn) begin
        mReg = (mReg & ~DIVM) | (wrData & DIVM); mDirty = 1; rdTag = "R8";
      end
    end
  end

  task automatic doWrite(input bit full, input bit dw, input logic [31:0] d);
    @(posedge clk); #2;
    regWrEn = full; divWrEn = dw; wrData = d;
    @(posedge clk); #2;
    regWrEn = 1'b0; divWrEn = 1'b0; wrData = $urandom;
  endtask

  task automatic measure(output int n);
    do @(negedge clk); while (!riseEn);
    n = 0;
    do begin @(negedge clk); n++; end while (!riseEn);
  endtask

  task automatic settleAndMeasure(input int exp, input string tag);
    int n;
    measure(n); measure(n); measure(n);
    chk(n == exp, tag, "period", n, exp);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int n;
    void'($urandom(32'h1234_5678));
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk(rdData == 32'h0, "R1", "reset readback", rdData, 0);
    chk(riseEn && launchEn, "R1", "first rise", {riseEn, launchEn}, 2'b11);
    settleAndMeasure(2, "R1");

    // R3: high fragment 2, low 5 -> field 69, ratio 71
    r = mkReg(0, 0, 2, 5, 32'h03A5_5740);
    doWrite(1, 0, r);
    settleAndMeasure(ratioOf(r), "R3");

    // R6: change ratio just after a rise; current period keeps 71
    do @(negedge clk); while (!riseEn);
    @(posedge clk); #2;
    regWrEn = 1'b1; wrData = mkReg(0, 0, 0, 0, 32'h03A5_5740);
    @(negedge clk); n = 1;
    @(posedge clk); #2; regWrEn = 1'b0;
    do begin @(negedge clk); n++; end while (!riseEn);
    chk(n == 71, "R6", "old period kept", n, 71);
    measure(n);
    chk(n == 2, "R6", "new period", n, 2);

    // R2: bypass with a non-zero field, via divisor-only write
    doWrite(0, 1, mkReg(1, 0, 7, 9, '1));
    settleAndMeasure(1, "R2");

    // R3: largest ratio via divisor-only write; other bits kept (R8)
    doWrite(0, 1, mkReg(0, 0, 31, 31, '0));
    settleAndMeasure(1025, "R3");

    // R5: inversion with odd ratio 5
    doWrite(1, 0, mkReg(0, 1, 0, 3, 32'h0012_3400));
    settleAndMeasure(5, "R5");

    // R9: colliding writes, full write wins
    doWrite(1, 1, mkReg(0, 0, 0, 4, 32'h0000_0100));
    settleAndMeasure(6, "R9");

    // Random mix
    for (int i = 0; i < 60; i++) begin
      int kind;
      kind = $urandom_range(0, 2);
      r = mkReg(($urandom_range(0, 3) == 0), $urandom_range(0, 1),
                $urandom_range(0, 1), $urandom_range(0, 31), $urandom);
      doWrite(kind != 1, kind != 0, r);
      repeat ($urandom_range(1, 150)) @(posedge clk);
    end
    repeat (200) @(posedge clk);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule